// File: doc/BRIEF.md
# Stereo Linear Crossfade Mixer

The block blends two stereo streams of signed samples, one frame at a time. One stream is a fading-out source (called the reverse stream) and the other is a fading-in source (the forward stream). A gain register is loaded with full scale when a start pulse arrives. On each frame strobe the gain first drops by a fixed step, and then weights the reverse sample. The forward sample is weighted by the ones complement of that gain. The two products are added, and the upper half of the sum becomes the output sample. Both channels share the one gain.

When the step subtraction reaches exactly zero or borrows, the ramp is over. That frame delivers the forward samples unchanged and raises a one-cycle done pulse. From then on every frame passes the forward stream through until the next start. With the default step of 0x0080 from 0xFFFF, frames 1 to 511 are mixed and frame 512 ends the ramp. At a 44.1 kHz frame rate this is about 11.6 ms.

Top module: `stereo_xfade_mixer`

## Requirements
- R1: After the asynchronous active-low reset, both outputs are 0, done_o is 0 and the block is idle. No ramp runs until start_i is seen.
- R2: A cycle with start_i high loads the gain with all ones (0xFFFF) and begins a ramp. When frame_i is high in the same cycle, the frame is ignored and the outputs keep their previous values.
- R3: During a ramp, each frame with start_i low first forms g = gain - STEP (STEP = 0x0080 by default). When no end occurs, the gain register takes g. One cycle after the frame strobe, each output equals bits [31:16] of rev*g + fwd*(0xFFFF - g), the sum being signed.
- R4: The reverse and forward samples are treated as signed 16-bit values, and the gain as unsigned. Full-scale negative samples (0x8000) give the exact floor of the weighted sum without wrapping.
- R5: The left and right channels use the same gain on every frame.
- R6: A frame whose subtraction gives exactly zero or borrows ends the ramp. That frame outputs the forward samples unchanged and pulses done_o high for exactly one cycle. With the defaults this is the 512th frame after start. With STEP = 0x0101 the subtraction reaches zero exactly, and that is the 255th frame.
- R7: On a frame outside a ramp, the outputs take the forward samples unchanged and done_o stays low.
- R8: The outputs and done_o change only in the cycle after a frame strobe. Between strobes they hold, whatever the sample inputs do.
- R9: A start pulse in the middle of a ramp restarts the ramp from 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin or restart a ramp |
| frame_i | input | 1 | One-cycle strobe per stereo frame |
| rev_l_i | input | 16 | Fading-out left sample, signed |
| rev_r_i | input | 16 | Fading-out right sample, signed |
| fwd_l_i | input | 16 | Fading-in left sample, signed |
| fwd_r_i | input | 16 | Fading-in right sample, signed |
| mix_l_o | output | 16 | Mixed left sample, signed |
| mix_r_o | output | 16 | Mixed right sample, signed |
| done_o | output | 1 | One-cycle pulse on the frame that ends the ramp |

## Verification
The hardest case to reach from the ports is a ramp that ends on an exact zero. With the default step this never happens, because 0xFFFF is not a multiple of 0x0080. The bench therefore places a second instance with step 0x0101 beside the default one, drives it with the same stimulus, and checks that it ends on its 255th frame. Random samples drive full ramps. Directed frames place 0x8000 and 0x7FFF on both sources to exercise full-scale products, and start pulses are applied both alongside a frame strobe and in mid-ramp.

// File: rtl/xf_pkg.sv
package xf_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned DEF_SAMPLE_W = 16;
  localparam int unsigned DEF_GAIN_W = 16;

  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_FWD  = 2'd1,
    SRC_MIX  = 2'd2
  } out_sel_e;
endpackage

// File: rtl/xf_gain_ramp.sv
module xf_gain_ramp #(
  parameter int unsigned GAIN_W = 16,
  parameter logic [GAIN_W-1:0] STEP = 16'h0080
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              frame_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic [GAIN_W-1:0] next_gain_o,
  output logic              fading_o,
  output logic              last_o
);
  logic [GAIN_W-1:0] gain_q;
  logic              fading_q;
  logic [GAIN_W:0]   diff;
  logic              borrow, zero;

  assign diff   = {1'b0, gain_q} - {1'b0, STEP};
  assign borrow = diff[GAIN_W];
  assign zero   = (diff[GAIN_W-1:0] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_q   <= '0;
      fading_q <= 1'b0;
    end else if (start_i) begin
      gain_q   <= '1;
      fading_q <= 1'b1;
    end else if (frame_i && fading_q) begin
      if (borrow || zero) begin
        gain_q   <= '0;
        fading_q <= 1'b0;
      end else begin
        gain_q   <= diff[GAIN_W-1:0];
      end
    end
  end

  assign gain_o      = gain_q;
  assign next_gain_o = diff[GAIN_W-1:0];
  assign fading_o    = fading_q;
  assign last_o      = fading_q && (borrow || zero);
endmodule

// File: rtl/xf_chan_mix.sv
module xf_chan_mix #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned GAIN_W   = 16
) (
  input  logic [SAMPLE_W-1:0] rev_i,
  input  logic [SAMPLE_W-1:0] fwd_i,
  input  logic [GAIN_W-1:0]   gain_i,
  output logic [SAMPLE_W-1:0] mix_o
);
  // one spare bit keeps signed x unsigned products exact
  localparam int unsigned PW = SAMPLE_W + GAIN_W + 1;

  logic signed [PW-1:0] rev_x, fwd_x, g_x, gc_x;
  logic signed [PW-1:0] rev_p, fwd_p, sum;

  assign rev_x = {{(GAIN_W+1){rev_i[SAMPLE_W-1]}}, rev_i};
  assign fwd_x = {{(GAIN_W+1){fwd_i[SAMPLE_W-1]}}, fwd_i};
  assign g_x   = {{(SAMPLE_W+1){1'b0}}, gain_i};
  assign gc_x  = {{(SAMPLE_W+1){1'b0}}, ~gain_i};

  assign rev_p = rev_x * g_x;
  assign fwd_p = fwd_x * gc_x;
  assign sum   = rev_p + fwd_p;
  assign mix_o = sum[SAMPLE_W+GAIN_W-1:GAIN_W];
endmodule

// File: rtl/stereo_xfade_mixer.sv
module stereo_xfade_mixer
  import xf_pkg::*;
#(
  parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
  parameter int unsigned GAIN_W   = DEF_GAIN_W,
  parameter logic [GAIN_W-1:0] STEP = 16'h0080
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                frame_i,
  input  logic [SAMPLE_W-1:0] rev_l_i,
  input  logic [SAMPLE_W-1:0] rev_r_i,
  input  logic [SAMPLE_W-1:0] fwd_l_i,
  input  logic [SAMPLE_W-1:0] fwd_r_i,
  output logic [SAMPLE_W-1:0] mix_l_o,
  output logic [SAMPLE_W-1:0] mix_r_o,
  output logic                done_o
);
  logic [GAIN_W-1:0]   gain_w, next_gain_w;
  logic                fading_w, last_w;
  logic [SAMPLE_W-1:0] rev_a [NUM_CH];
  logic [SAMPLE_W-1:0] fwd_a [NUM_CH];
  logic [SAMPLE_W-1:0] mix_a [NUM_CH];
  logic [SAMPLE_W-1:0] out_q [NUM_CH];
  logic                done_q;
  out_sel_e            sel;

  assign rev_a[0] = rev_l_i;
  assign rev_a[1] = rev_r_i;
  assign fwd_a[0] = fwd_l_i;
  assign fwd_a[1] = fwd_r_i;

  xf_gain_ramp #(.GAIN_W(GAIN_W), .STEP(STEP)) i_ramp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .frame_i    (frame_i),
    .gain_o     (gain_w),
    .next_gain_o(next_gain_w),
    .fading_o   (fading_w),
    .last_o     (last_w)
  );

  always_comb begin
    if (start_i || !frame_i)        sel = SRC_HOLD;
    else if (fading_w && !last_w)   sel = SRC_MIX;
    else                            sel = SRC_FWD;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    xf_chan_mix #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) i_mix (
      .rev_i (rev_a[ch]),
      .fwd_i (fwd_a[ch]),
      .gain_i(next_gain_w),
      .mix_o (mix_a[ch])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              out_q[ch] <= '0;
      else if (sel == SRC_MIX)  out_q[ch] <= mix_a[ch];
      else if (sel == SRC_FWD)  out_q[ch] <= fwd_a[ch];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= frame_i && !start_i && last_w;
  end

  assign mix_l_o = out_q[0];
  assign mix_r_o = out_q[1];
  assign done_o  = done_q;
endmodule

// File: rtl/xf_checker.sv
module xf_checker #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned GAIN_W   = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                frame_i,
  input logic [SAMPLE_W-1:0] fwd_l_i,
  input logic [SAMPLE_W-1:0] fwd_r_i,
  input logic [SAMPLE_W-1:0] mix_l_o,
  input logic [SAMPLE_W-1:0] mix_r_o,
  input logic                done_o,
  input logic [GAIN_W-1:0]   gain_w,
  input logic                fading_w
);
  // R2
  start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (fading_w && gain_w == '1));

  // R3
  gain_falls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && fading_w && !start_i) |=> (!fading_w || gain_w < $past(gain_w)));

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  done_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (mix_l_o == $past(fwd_l_i) && mix_r_o == $past(fwd_r_i) && !fading_w));

  // R7
  idle_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !fading_w && !start_i) |=> (mix_l_o == $past(fwd_l_i) && mix_r_o == $past(fwd_r_i) && !done_o));

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> ($stable(mix_l_o) && $stable(mix_r_o) && !done_o));
endmodule

bind stereo_xfade_mixer xf_checker #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) i_xf_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .frame_i (frame_i),
  .fwd_l_i (fwd_l_i),
  .fwd_r_i (fwd_r_i),
  .mix_l_o (mix_l_o),
  .mix_r_o (mix_r_o),
  .done_o  (done_o),
  .gain_w  (gain_w),
  .fading_w(fading_w)
);

// File: tb/test_stereo_xfade_mixer.sv
module test_stereo_xfade_mixer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, frame = 1'b0;
  logic [15:0] rev_l = '0, rev_r = '0, fwd_l = '0, fwd_r = '0;
  logic [15:0] ml_a, mr_a, ml_b, mr_b;
  logic done_a, done_b;
  int n_chk = 0, n_bad = 0;

  // bench model state: [0] default step, [1] zero-ending step
  int  g_m [2];
  bit  f_m [2];
  int  step_m [2];
  logic [15:0] exl [2], exr [2];
  bit  exd [2];

  always #4 clk = ~clk;

  stereo_xfade_mixer i_stereo_xfade_mixer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .frame_i(frame),
    .rev_l_i(rev_l), .rev_r_i(rev_r), .fwd_l_i(fwd_l), .fwd_r_i(fwd_r),
    .mix_l_o(ml_a), .mix_r_o(mr_a), .done_o(done_a));

  stereo_xfade_mixer #(.STEP(16'h0101)) i_stereo_xfade_mixer_zstep (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .frame_i(frame),
    .rev_l_i(rev_l), .rev_r_i(rev_r), .fwd_l_i(fwd_l), .fwd_r_i(fwd_r),
    .mix_l_o(ml_b), .mix_r_o(mr_b), .done_o(done_b));

  function automatic logic [15:0] mix_ref(logic [15:0] rv, logic [15:0] fw, int g);
    longint s;
    s = longint'($signed(rv)) * longint'(g) + longint'($signed(fw)) * longint'(65535 - g);
    s = s >>> 16;
    return s[15:0];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model_frame(int k);
    int d;
    exd[k] = 1'b0;
    if (!f_m[k]) begin
      exl[k] = fwd_l; exr[k] = fwd_r;
      return;
    end
    d = g_m[k] - step_m[k];
    if (d <= 0) begin
      f_m[k] = 1'b0; g_m[k] = 0;
      exl[k] = fwd_l; exr[k] = fwd_r; exd[k] = 1'b1;
    end else begin
      g_m[k] = d;
      exl[k] = mix_ref(rev_l, fwd_l, d);
      exr[k] = mix_ref(rev_r, fwd_r, d);
    end
  endfunction

  task automatic do_frame(logic [15:0] rl, logic [15:0] rr, logic [15:0] fl, logic [15:0] fr);
    @(negedge clk);
    rev_l = rl; rev_r = rr; fwd_l = fl; fwd_r = fr; frame = 1'b1;
    model_frame(0); model_frame(1);
    @(negedge clk);
    frame = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 2; k++) begin g_m[k] = 65535; f_m[k] = 1'b1; end
  endtask

  task automatic chk_out(string req);
    chk(req, {16'h0, ml_a}, {16'h0, exl[0]});
    chk(req, {16'h0, mr_a}, {16'h0, exr[0]});
    chk(req, {31'h0, done_a}, {31'h0, exd[0]});
  endtask

  task automatic rnd_frame(string req);
    do_frame(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
    chk_out(req);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cnt;
    int done_at;
    logic [15:0] hl, hr;
    void'($urandom(32'd1234));
    step_m[0] = 32'h80; step_m[1] = 32'h101;
    for (int k = 0; k < 2; k++) begin g_m[k] = 0; f_m[k] = 1'b0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {ml_a, mr_a}, 32'h0);
    chk("R1", {31'h0, done_a}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1/R7 idle frames pass forward
    for (int i = 0; i < 4; i++) rnd_frame("R7");

    // R2, R3, R5, R6 full default ramp
    do_start();
    // first frame gain 0xFF7F: near reverse sample
    do_frame(16'h1234, 16'hEDCC, 16'h4000, 16'hC000);
    chk_out("R3");
    chk("R3", {31'h0, (($signed(ml_a) - 16'sh1234) inside {[-16'sd150:16'sd150]})}, 32'h1);
    // R5 same samples on both channels give equal outputs
    do_frame(16'h5A5A, 16'h5A5A, 16'hA5A5, 16'hA5A5);
    chk_out("R5");
    chk("R5", {16'h0, ml_a}, {16'h0, mr_a});
    // R4 full-scale corners
    do_frame(16'h8000, 16'h7FFF, 16'h8000, 16'h7FFF);
    chk_out("R4");
    do_frame(16'h8000, 16'h8000, 16'h7FFF, 16'h8000);
    chk_out("R4");
    cnt = 4; done_at = 0;
    while (cnt < 600 && done_at == 0) begin
      rnd_frame("R3");
      cnt++;
      if (done_a) done_at = cnt;
      // R8 hold between strobes
      if (cnt == 100) begin
        hl = ml_a; hr = mr_a;
        @(negedge clk);
        rev_l = ~rev_l; fwd_l = ~fwd_l; fwd_r = ~fwd_r;
        repeat (3) @(negedge clk);
        chk("R8", {ml_a, mr_a}, {hl, hr});
        chk("R8", {31'h0, done_a}, 32'h0);
      end
    end
    // R6 ends on frame 512 of the default ramp
    chk("R6", done_at, 512);
    @(negedge clk);
    chk("R6", {31'h0, done_a}, 32'h0);
    rnd_frame("R7");

    // R6 exact-zero end on the second instance
    do_start();
    cnt = 0; done_at = 0;
    while (cnt < 300 && done_at == 0) begin
      do_frame(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
      cnt++;
      chk("R6", {ml_b, mr_b}, {exl[1], exr[1]});
      if (done_b) done_at = cnt;
    end
    chk("R6", done_at, 255);
    // default instance still fading: 255 frames in
    chk("R6", {31'h0, done_a}, 32'h0);

    // R9 restart mid-ramp
    do_start();
    for (int i = 0; i < 3; i++) rnd_frame("R9");

    // R2 start together with frame: frame ignored
    hl = ml_a; hr = mr_a;
    @(negedge clk);
    start = 1'b1; frame = 1'b1;
    rev_l = 16'h7777; fwd_l = 16'h1111; fwd_r = 16'h2222;
    @(negedge clk);
    start = 1'b0; frame = 1'b0;
    for (int k = 0; k < 2; k++) begin g_m[k] = 65535; f_m[k] = 1'b1; end
    chk("R2", {ml_a, mr_a}, {hl, hr});
    rnd_frame("R2");
    for (int i = 0; i < 20; i++) rnd_frame("R3");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule